// File: doc/BRIEF.md
# USB PHY Power-Up Reset Sequencer

This block brings a combined USB2/USB3 PHY and the USB controller behind it out of reset in a fixed order. It drives every reset and power-control line directly from registers: four active-low resets, the IDDQ and test power-down controls, three power-stable flags, spread-spectrum enable, four forced VBUS-valid lines, a 2-bit reference-clock select code, a pad-use flag and a reference-clock enable. A pulse on `init_start` runs the whole bring-up. A pulse on `exit_start` puts the PHY back into reset and gates its reference clock.

The three settling waits are counted in system clock cycles. Their length is `WAIT_US * CYC_PER_US`, so a simulation can shorten them through the cycles-per-microsecond parameter. The last step of bring-up tunes the transmit boost. The block reads a control register through a request/acknowledge port, retries only when the read times out, merges in an enable bit and a boost level, and writes the result back. A write completes the sequence with `done`. Any port error, or running out of read attempts, stops the sequence and raises a sticky `err` instead.

Top module: `usbphy_pwrseq`

## Requirements
- R1: After synchronous reset, the four resets (`aux_rst_n`, `ctrl_rst_n`, `phy3_rst_n`, `phy2_por_n`) are low. `iddq` and `test_pwrdn` are high. Every other control output is low, `refclk_code` is 2'b00, and `done`, `err` and `cr_req` are low.
- R2: `init_start` is accepted only in idle, done or error. The first step returns all control outputs to their R1 values and clears `done` and `err`. While a sequence is running, both `init_start` and `exit_start` have no effect.
- R3: `pad_clk_strap` selects the reference clock. When it is high, `refclk_code` becomes 2'b10 and `refpad_use` goes high. When it is low, `refclk_code` becomes 2'b11 and `refpad_use` stays low. `refclk_en` goes high in both cases.
- R4: `iddq` and `test_pwrdn` fall together. Exactly one cycle later, `phy3_rst_n` and `phy2_por_n` rise together.
- R5: `ana_pwr_en`, `pcs_pwr_stable` and `pma_pwr_stable` rise in the same cycle. That cycle comes exactly DLY = `WAIT_US*CYC_PER_US` cycles after the PHY reset release.
- R6: `ssc_en` rises one cycle after the power-stable flags. `aux_rst_n` and `ctrl_rst_n` rise together one cycle after `ssc_en`.
- R7: `vbus3_val`, `vbus3_sel`, `vbus2_val` and `vbus2_sel` rise together DLY cycles after the controller reset release. The first tuning request appears DLY+1 cycles after that.
- R8: The port holds `cr_req`, `cr_write`, `cr_addr` and `cr_wdata` stable until a one-cycle `cr_ack`. `cr_status` means 2'b00 success, 2'b01 timeout, and 2'b10 or 2'b11 error. The tuning read goes to `TUNE_ADDR` (default 0x000F) with `cr_write` low.
- R9: After a successful read, the block writes to the same address the read data OR bit 9 OR (`BOOST_LVL` << 6), with a default level of 5. Bits already set stay set. A successful write raises `done`.
- R10: A read timeout is retried, for at most `MAX_TRIES` (3) read attempts in total. If the last attempt also times out, the block makes no write, leaves `done` low and holds `err` high until the next accepted `init_start`.
- R11: A read returning error status, or a write returning any non-success status, raises `err` with no retry. `done` stays low.
- R12: `exit_start`, accepted in idle, done or error, drives `phy3_rst_n`, `phy2_por_n`, `refclk_en` and `done` low on the next edge. All other controls are left unchanged.
- R13: When `init_start` and `exit_start` arrive in the same cycle, the exit is performed and the init is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| init_start | input | 1 | Start the bring-up sequence |
| exit_start | input | 1 | Return the PHY to reset |
| pad_clk_strap | input | 1 | 1 selects the external pad reference clock |
| aux_rst_n | output | 1 | Auxiliary reset, active low |
| ctrl_rst_n | output | 1 | Controller reset, active low |
| phy3_rst_n | output | 1 | USB3 PHY reset, active low |
| phy2_por_n | output | 1 | USB2 PHY power-on reset, active low |
| iddq | output | 1 | USB2 PHY IDDQ mode |
| test_pwrdn | output | 1 | USB3 PHY test power-down |
| ana_pwr_en | output | 1 | Analog power enable |
| pcs_pwr_stable | output | 1 | PCS power stable |
| pma_pwr_stable | output | 1 | PMA power stable |
| ssc_en | output | 1 | Spread-spectrum clocking enable |
| vbus3_val | output | 1 | Forced USB3 VBUS-valid value |
| vbus3_sel | output | 1 | USB3 VBUS-valid override select |
| vbus2_val | output | 1 | Forced USB2 VBUS-valid value |
| vbus2_sel | output | 1 | USB2 VBUS-valid override select |
| refclk_code | output | 2 | Reference clock select code |
| refpad_use | output | 1 | USB3 PHY uses the pad reference clock |
| refclk_en | output | 1 | PHY reference clock enable |
| done | output | 1 | Bring-up completed |
| err | output | 1 | Sticky failure flag |
| cr_req | output | 1 | Control-register request |
| cr_write | output | 1 | 1 write, 0 read |
| cr_addr | output | 16 | Control-register address |
| cr_wdata | output | 16 | Write data |
| cr_ack | input | 1 | One-cycle acknowledge |
| cr_status | input | 2 | Completion status |
| cr_rdata | input | 16 | Read data, valid with `cr_ack` |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a start and an exit request. The bench raises `init_start` and `exit_start` together while the block is idle with the auxiliary reset released. It judges the outcome by the auxiliary reset staying high and no request reaching the register port. The bench also applies the same pair in the middle of a running sequence, where both must be ignored. That is judged by the released resets staying high and the tuning request keeping its DLY+1 timing.

The second pair is a timeout acknowledge and the retry limit. The responder times out on exactly the last permitted attempt, and the bench counts the attempts and checks that no write follows.

// File: rtl/usbpwr_pkg.sv
package usbpwr_pkg;

    parameter int CR_AW        = 16;
    parameter int CR_DW        = 16;
    parameter int BOOST_EN_BIT = 9;
    parameter int BOOST_SHIFT  = 6;

    // completion status on the register port
    localparam logic [1:0] CR_OK  = 2'b00;
    localparam logic [1:0] CR_TMO = 2'b01;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CLKSEL,
        S_PWRUP,
        S_PHYREL,
        S_WAIT_PHY,
        S_SSC,
        S_CTLREL,
        S_WAIT_CTL,
        S_WAIT_VBUS,
        S_TUNE,
        S_DONE,
        S_ERR
    } seq_state_e;

    typedef enum logic [1:0] {
        T_IDLE,
        T_RD,
        T_GAP,
        T_WR
    } tune_state_e;

    typedef struct packed {
        logic       aux_rst_n;
        logic       ctrl_rst_n;
        logic       phy3_rst_n;
        logic       phy2_por_n;
        logic       iddq;
        logic       test_pwrdn;
        logic       ana_pwr_en;
        logic       pcs_stable;
        logic       pma_stable;
        logic       ssc_en;
        logic       vbus3_val;
        logic       vbus3_sel;
        logic       vbus2_val;
        logic       vbus2_sel;
        logic [1:0] refclk_code;
        logic       refpad_use;
        logic       refclk_en;
    } phy_ctl_t;

    function automatic phy_ctl_t ctl_reset_value();
        phy_ctl_t c;
        c            = '0;
        c.iddq       = 1'b1;
        c.test_pwrdn = 1'b1;
        return c;
    endfunction

    function automatic logic [CR_DW-1:0] boost_merge(
        input logic [CR_DW-1:0] rd,
        input logic [CR_DW-1:0] lvl
    );
        return rd | (CR_DW'(1) << BOOST_EN_BIT) | (lvl << BOOST_SHIFT);
    endfunction

endpackage

// File: rtl/usbpwr_delay.sv
module usbpwr_delay #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !load) |=> (cnt == '0));

endmodule

// File: rtl/usbpwr_tuner.sv
module usbpwr_tuner
    import usbpwr_pkg::*;
#(
    parameter logic [CR_AW-1:0] TUNE_ADDR = 16'h000F,
    parameter int               BOOST_LVL = 5,
    parameter int               MAX_TRIES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    output logic             tune_done,
    output logic             tune_fail,
    output logic             cr_req,
    output logic             cr_write,
    output logic [CR_AW-1:0] cr_addr,
    output logic [CR_DW-1:0] cr_wdata,
    input  logic             cr_ack,
    input  logic [1:0]       cr_status,
    input  logic [CR_DW-1:0] cr_rdata
);

    localparam int TW = $clog2(MAX_TRIES + 1);
    localparam logic [CR_DW-1:0] LVL_W = CR_DW'(BOOST_LVL);

    tune_state_e   st;
    logic [TW-1:0] tries;
    logic          nxt_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= T_IDLE;
            tries     <= '0;
            nxt_write <= 1'b0;
            cr_req    <= 1'b0;
            cr_write  <= 1'b0;
            cr_addr   <= '0;
            cr_wdata  <= '0;
            tune_done <= 1'b0;
            tune_fail <= 1'b0;
        end else begin
            tune_done <= 1'b0;
            tune_fail <= 1'b0;
            case (st)
                T_IDLE: begin
                    if (go) begin
                        cr_req   <= 1'b1;
                        cr_write <= 1'b0;
                        cr_addr  <= TUNE_ADDR;
                        tries    <= TW'(1);
                        st       <= T_RD;
                    end
                end
                T_RD: begin
                    if (cr_ack) begin
                        cr_req <= 1'b0;
                        if (cr_status == CR_OK) begin
                            cr_wdata  <= boost_merge(cr_rdata, LVL_W);
                            nxt_write <= 1'b1;
                            st        <= T_GAP;
                        end else if (cr_status == CR_TMO && tries != TW'(MAX_TRIES)) begin
                            tries     <= tries + 1'b1;
                            nxt_write <= 1'b0;
                            st        <= T_GAP;
                        end else begin
                            tune_fail <= 1'b1;
                            st        <= T_IDLE;
                        end
                    end
                end
                T_GAP: begin
                    cr_req   <= 1'b1;
                    cr_write <= nxt_write;
                    st       <= nxt_write ? T_WR : T_RD;
                end
                T_WR: begin
                    if (cr_ack) begin
                        cr_req <= 1'b0;
                        if (cr_status == CR_OK) begin
                            tune_done <= 1'b1;
                        end else begin
                            tune_fail <= 1'b1;
                        end
                        st <= T_IDLE;
                    end
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cr_req && !cr_ack) |=> (cr_req && $stable(cr_addr) && $stable(cr_write) && $stable(cr_wdata)));

    // R10
    tries_limit_chk: assert property (@(posedge clk) disable iff (rst)
        tries <= TW'(MAX_TRIES));

    // R9
    wr_enbit_chk: assert property (@(posedge clk) disable iff (rst)
        (cr_req && cr_write) |-> cr_wdata[BOOST_EN_BIT]);

endmodule

// File: rtl/usbphy_pwrseq.sv
module usbphy_pwrseq
    import usbpwr_pkg::*;
#(
    parameter int               CYC_PER_US = 200,
    parameter int               WAIT_US    = 100,
    parameter logic [CR_AW-1:0] TUNE_ADDR  = 16'h000F,
    parameter int               BOOST_LVL  = 5,
    parameter int               MAX_TRIES  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init_start,
    input  logic             exit_start,
    input  logic             pad_clk_strap,
    output logic             aux_rst_n,
    output logic             ctrl_rst_n,
    output logic             phy3_rst_n,
    output logic             phy2_por_n,
    output logic             iddq,
    output logic             test_pwrdn,
    output logic             ana_pwr_en,
    output logic             pcs_pwr_stable,
    output logic             pma_pwr_stable,
    output logic             ssc_en,
    output logic             vbus3_val,
    output logic             vbus3_sel,
    output logic             vbus2_val,
    output logic             vbus2_sel,
    output logic [1:0]       refclk_code,
    output logic             refpad_use,
    output logic             refclk_en,
    output logic             done,
    output logic             err,
    output logic             cr_req,
    output logic             cr_write,
    output logic [CR_AW-1:0] cr_addr,
    output logic [CR_DW-1:0] cr_wdata,
    input  logic             cr_ack,
    input  logic [1:0]       cr_status,
    input  logic [CR_DW-1:0] cr_rdata
);

    localparam int DLY = CYC_PER_US * WAIT_US;
    localparam int CW  = $clog2(DLY + 1);
    localparam logic [CW-1:0] DLY_M1 = CW'(DLY - 1);

    seq_state_e st;
    phy_ctl_t   ctl;
    logic       tmr_load;
    logic       tmr_exp;
    logic       tune_go;
    logic       tune_done;
    logic       tune_fail;
    logic       quiet;

    assign quiet = (st == S_IDLE) || (st == S_DONE) || (st == S_ERR);

    // the timer is loaded on the edge that performs each release step
    always_comb begin
        tmr_load = 1'b0;
        case (st)
            S_PHYREL:   tmr_load = 1'b1;
            S_CTLREL:   tmr_load = 1'b1;
            S_WAIT_CTL: tmr_load = tmr_exp;
            default:    tmr_load = 1'b0;
        endcase
    end

    usbpwr_delay #(.CW(CW)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (DLY_M1),
        .expired  (tmr_exp)
    );

    usbpwr_tuner #(
        .TUNE_ADDR (TUNE_ADDR),
        .BOOST_LVL (BOOST_LVL),
        .MAX_TRIES (MAX_TRIES)
    ) u_tuner (
        .clk       (clk),
        .rst       (rst),
        .go        (tune_go),
        .tune_done (tune_done),
        .tune_fail (tune_fail),
        .cr_req    (cr_req),
        .cr_write  (cr_write),
        .cr_addr   (cr_addr),
        .cr_wdata  (cr_wdata),
        .cr_ack    (cr_ack),
        .cr_status (cr_status),
        .cr_rdata  (cr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            ctl     <= ctl_reset_value();
            done    <= 1'b0;
            err     <= 1'b0;
            tune_go <= 1'b0;
        end else begin
            tune_go <= 1'b0;
            case (st)
                S_IDLE, S_DONE, S_ERR: begin
                    if (exit_start) begin
                        ctl.phy3_rst_n <= 1'b0;
                        ctl.phy2_por_n <= 1'b0;
                        ctl.refclk_en  <= 1'b0;
                        done           <= 1'b0;
                        if (st == S_DONE) st <= S_IDLE;
                    end else if (init_start) begin
                        ctl  <= ctl_reset_value();
                        done <= 1'b0;
                        err  <= 1'b0;
                        st   <= S_CLKSEL;
                    end
                end
                S_CLKSEL: begin
                    ctl.refclk_code <= pad_clk_strap ? 2'b10 : 2'b11;
                    ctl.refpad_use  <= pad_clk_strap;
                    ctl.refclk_en   <= 1'b1;
                    st              <= S_PWRUP;
                end
                S_PWRUP: begin
                    ctl.iddq       <= 1'b0;
                    ctl.test_pwrdn <= 1'b0;
                    st             <= S_PHYREL;
                end
                S_PHYREL: begin
                    ctl.phy3_rst_n <= 1'b1;
                    ctl.phy2_por_n <= 1'b1;
                    st             <= S_WAIT_PHY;
                end
                S_WAIT_PHY: begin
                    if (tmr_exp) begin
                        ctl.ana_pwr_en <= 1'b1;
                        ctl.pcs_stable <= 1'b1;
                        ctl.pma_stable <= 1'b1;
                        st             <= S_SSC;
                    end
                end
                S_SSC: begin
                    ctl.ssc_en <= 1'b1;
                    st         <= S_CTLREL;
                end
                S_CTLREL: begin
                    ctl.aux_rst_n  <= 1'b1;
                    ctl.ctrl_rst_n <= 1'b1;
                    st             <= S_WAIT_CTL;
                end
                S_WAIT_CTL: begin
                    if (tmr_exp) begin
                        ctl.vbus3_val <= 1'b1;
                        ctl.vbus3_sel <= 1'b1;
                        ctl.vbus2_val <= 1'b1;
                        ctl.vbus2_sel <= 1'b1;
                        st            <= S_WAIT_VBUS;
                    end
                end
                S_WAIT_VBUS: begin
                    if (tmr_exp) begin
                        tune_go <= 1'b1;
                        st      <= S_TUNE;
                    end
                end
                S_TUNE: begin
                    if (tune_done) begin
                        done <= 1'b1;
                        st   <= S_DONE;
                    end else if (tune_fail) begin
                        err <= 1'b1;
                        st  <= S_ERR;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign aux_rst_n      = ctl.aux_rst_n;
    assign ctrl_rst_n     = ctl.ctrl_rst_n;
    assign phy3_rst_n     = ctl.phy3_rst_n;
    assign phy2_por_n     = ctl.phy2_por_n;
    assign iddq           = ctl.iddq;
    assign test_pwrdn     = ctl.test_pwrdn;
    assign ana_pwr_en     = ctl.ana_pwr_en;
    assign pcs_pwr_stable = ctl.pcs_stable;
    assign pma_pwr_stable = ctl.pma_stable;
    assign ssc_en         = ctl.ssc_en;
    assign vbus3_val      = ctl.vbus3_val;
    assign vbus3_sel      = ctl.vbus3_sel;
    assign vbus2_val      = ctl.vbus2_val;
    assign vbus2_sel      = ctl.vbus2_sel;
    assign refclk_code    = ctl.refclk_code;
    assign refpad_use     = ctl.refpad_use;
    assign refclk_en      = ctl.refclk_en;

    // R10
    done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    // R4
    phy_rel_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(phy3_rst_n) |-> (!iddq && !test_pwrdn && phy2_por_n));

    // R5
    stable_after_phy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pcs_pwr_stable) |-> (phy3_rst_n && phy2_por_n && ana_pwr_en && pma_pwr_stable));

    // R6
    ctl_rel_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_rst_n) |-> (aux_rst_n && ssc_en && pma_pwr_stable && phy3_rst_n));

    // R7
    vbus_after_ctl_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vbus3_val) |-> (ctrl_rst_n && vbus3_sel && vbus2_val && vbus2_sel));

endmodule

// File: tb/usbphy_pwrseq_bench.sv
`timescale 1ns/1ps
module usbphy_pwrseq_bench;

    localparam int CPU = 2;
    localparam int WUS = 100;
    localparam int DLY = CPU * WUS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_start = 1'b0;
    logic        exit_start = 1'b0;
    logic        pad_clk_strap = 1'b0;
    logic        aux_rst_n, ctrl_rst_n, phy3_rst_n, phy2_por_n;
    logic        iddq, test_pwrdn, ana_pwr_en, pcs_pwr_stable, pma_pwr_stable, ssc_en;
    logic        vbus3_val, vbus3_sel, vbus2_val, vbus2_sel;
    logic [1:0]  refclk_code;
    logic        refpad_use, refclk_en, done, err;
    logic        cr_req, cr_write;
    logic [15:0] cr_addr, cr_wdata;
    logic        cr_ack = 1'b0;
    logic [1:0]  cr_status = 2'b00;
    logic [15:0] cr_rdata = 16'h0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // responder configuration and observations
    int          n_tmo = 0;
    logic        rd_bad = 1'b0;
    logic        wr_bad = 1'b0;
    logic [15:0] rd_val = 16'h0;
    int          rd_count = 0;
    int          wr_count = 0;
    logic [15:0] rd_addr = 16'h0;
    logic [15:0] wr_addr = 16'h0;
    logic [15:0] wr_data = 16'h0;

    int t_iddq = -1, t_phy = -1, t_stab = -1, t_ssc = -1, t_ctl = -1, t_vbus = -1, t_req = -1;
    logic p_iddq = 1'b1, p_phy = 1'b0, p_stab = 1'b0, p_ssc = 1'b0, p_ctl = 1'b0, p_vbus = 1'b0, p_req = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    usbphy_pwrseq #(
        .CYC_PER_US (CPU),
        .WAIT_US    (WUS)
    ) u_usbphy_pwrseq (
        .clk(clk), .rst(rst), .init_start(init_start), .exit_start(exit_start),
        .pad_clk_strap(pad_clk_strap),
        .aux_rst_n(aux_rst_n), .ctrl_rst_n(ctrl_rst_n), .phy3_rst_n(phy3_rst_n),
        .phy2_por_n(phy2_por_n), .iddq(iddq), .test_pwrdn(test_pwrdn),
        .ana_pwr_en(ana_pwr_en), .pcs_pwr_stable(pcs_pwr_stable),
        .pma_pwr_stable(pma_pwr_stable), .ssc_en(ssc_en),
        .vbus3_val(vbus3_val), .vbus3_sel(vbus3_sel), .vbus2_val(vbus2_val),
        .vbus2_sel(vbus2_sel), .refclk_code(refclk_code), .refpad_use(refpad_use),
        .refclk_en(refclk_en), .done(done), .err(err),
        .cr_req(cr_req), .cr_write(cr_write), .cr_addr(cr_addr), .cr_wdata(cr_wdata),
        .cr_ack(cr_ack), .cr_status(cr_status), .cr_rdata(cr_rdata)
    );

    // edge-time monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (p_iddq && !iddq) t_iddq = cyc;
        if (!p_phy && phy3_rst_n) t_phy = cyc;
        if (!p_stab && pcs_pwr_stable) t_stab = cyc;
        if (!p_ssc && ssc_en) t_ssc = cyc;
        if (!p_ctl && ctrl_rst_n) t_ctl = cyc;
        if (!p_vbus && vbus3_val) t_vbus = cyc;
        if (!p_req && cr_req && t_req < 0) t_req = cyc;
        p_iddq = iddq; p_phy = phy3_rst_n; p_stab = pcs_pwr_stable;
        p_ssc = ssc_en; p_ctl = ctrl_rst_n; p_vbus = vbus3_val; p_req = cr_req;
    end

    // control-register responder: two-cycle latency, one-cycle ack
    initial begin
        forever begin
            @(negedge clk);
            if (cr_req) begin
                repeat (2) @(negedge clk);
                if (!cr_write) begin
                    rd_count++;
                    rd_addr = cr_addr;
                    if (rd_count <= n_tmo)  cr_status = 2'b01;
                    else if (rd_bad)        cr_status = 2'b10;
                    else                    cr_status = 2'b00;
                    cr_rdata = rd_val;
                end else begin
                    wr_count++;
                    wr_addr = cr_addr;
                    wr_data = cr_wdata;
                    cr_status = wr_bad ? 2'b11 : 2'b00;
                end
                cr_ack = 1'b1;
                @(negedge clk);
                cr_ack = 1'b0;
                cr_status = 2'b00;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_obs();
        rd_count = 0; wr_count = 0;
        t_iddq = -1; t_phy = -1; t_stab = -1; t_ssc = -1; t_ctl = -1; t_vbus = -1; t_req = -1;
    endtask

    task automatic pulse_init(input logic strap);
        pad_clk_strap = strap;
        clear_obs();
        @(negedge clk);
        init_start = 1'b1;
        @(negedge clk);
        init_start = 1'b0;
    endtask

    task automatic wait_end(input string req);
        int n;
        n = 0;
        while (!done && !err && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk({req, " sequence ends"}, (n < 5000), 1'b1);
    endtask

    task automatic test_reset();
        chk("R1 resets low", {aux_rst_n, ctrl_rst_n, phy3_rst_n, phy2_por_n}, 4'b0000);
        chk("R1 iddq/testpd high", {iddq, test_pwrdn}, 2'b11);
        chk("R1 other controls low",
            {ana_pwr_en, pcs_pwr_stable, pma_pwr_stable, ssc_en, vbus3_val, vbus3_sel,
             vbus2_val, vbus2_sel, refpad_use, refclk_en}, 10'h0);
        chk("R1 refclk code", refclk_code, 2'b00);
        chk("R1 done/err/req", {done, err, cr_req}, 3'b000);
    endtask

    task automatic test_init_pad();
        n_tmo = 0; rd_bad = 0; wr_bad = 0; rd_val = 16'h0000;
        pulse_init(1'b1);
        wait_end("R9");
        chk("R3 pad code", refclk_code, 2'b10);
        chk("R3 pad flag/clk en", {refpad_use, refclk_en}, 2'b11);
        chk("R4 iddq one cycle before phy release", t_phy - t_iddq, 1);
        chk("R4 phy2 por with phy3", {phy2_por_n, test_pwrdn}, 2'b10);
        chk("R5 stable delay", t_stab - t_phy, DLY);
        chk("R5 three flags", {ana_pwr_en, pcs_pwr_stable, pma_pwr_stable}, 3'b111);
        chk("R6 ssc after flags", t_ssc - t_stab, 1);
        chk("R6 ctl release after ssc", t_ctl - t_ssc, 1);
        chk("R6 aux with ctrl", {aux_rst_n, ctrl_rst_n}, 2'b11);
        chk("R7 vbus delay", t_vbus - t_ctl, DLY);
        chk("R7 vbus bits", {vbus3_val, vbus3_sel, vbus2_val, vbus2_sel}, 4'hF);
        chk("R7 request delay", t_req - t_vbus, DLY + 1);
        chk("R8 read address", rd_addr, 16'h000F);
        chk("R9 write address", wr_addr, 16'h000F);
        chk("R9 write value", wr_data, 16'h0340);
        chk("R9 done/err", {done, err}, 2'b10);
        chk("R10 single attempt", rd_count, 1);
    endtask

    task automatic test_exit();
        @(negedge clk);
        exit_start = 1'b1;
        @(negedge clk);
        exit_start = 1'b0;
        chk("R12 phy resets low", {phy3_rst_n, phy2_por_n}, 2'b00);
        chk("R12 refclk en low, done low", {refclk_en, done}, 2'b00);
        chk("R12 others unchanged", {aux_rst_n, ctrl_rst_n, vbus3_val, ssc_en, refclk_code}, 6'b111110);
    endtask

    task automatic test_simul();
        clear_obs();
        @(negedge clk);
        init_start = 1'b1;
        exit_start = 1'b1;
        @(negedge clk);
        init_start = 1'b0;
        exit_start = 1'b0;
        repeat (8) @(negedge clk);
        chk("R13 init ignored, aux held", {aux_rst_n, iddq}, 2'b10);
        chk("R13 no request", rd_count + ((t_req >= 0) ? 1 : 0), 0);
        chk("R13 exit applied", {phy3_rst_n, refclk_en, done}, 3'b000);
    endtask

    task automatic test_init_abb_retry();
        n_tmo = 2; rd_bad = 0; wr_bad = 0; rd_val = 16'h8081;
        pulse_init(1'b0);
        wait_end("R10");
        chk("R3 abb code", refclk_code, 2'b11);
        chk("R3 abb flag/clk en", {refpad_use, refclk_en}, 2'b01);
        chk("R10 attempts with two timeouts", rd_count, 3);
        chk("R9 merged value keeps bits", wr_data, 16'h83C1);
        chk("R10 done after retry", {done, err}, 2'b10);
    endtask

    task automatic test_busy_ignored();
        int n;
        n_tmo = 0; rd_bad = 0; wr_bad = 0; rd_val = 16'h0001;
        pulse_init(1'b1);
        n = 0;
        while (!aux_rst_n && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        exit_start = 1'b1;
        @(negedge clk);
        exit_start = 1'b0;
        chk("R2 exit ignored while busy", {phy3_rst_n, refclk_en}, 2'b11);
        repeat (3) @(negedge clk);
        init_start = 1'b1;
        @(negedge clk);
        init_start = 1'b0;
        chk("R2 init ignored while busy", {aux_rst_n, iddq}, 2'b10);
        wait_end("R2");
        chk("R2 timing unchanged", t_req - t_vbus, DLY + 1);
        chk("R2 completes once", {done, rd_count[3:0], wr_data}, {1'b1, 4'd1, 16'h0341});
    endtask

    task automatic test_exhaust();
        n_tmo = 3; rd_bad = 0; wr_bad = 0; rd_val = 16'h0;
        pulse_init(1'b1);
        wait_end("R10");
        chk("R10 attempts capped", rd_count, 3);
        chk("R10 no write", wr_count, 0);
        chk("R10 err not done", {done, err}, 2'b01);
        repeat (20) @(negedge clk);
        chk("R10 err sticky", {done, err, cr_req}, 3'b010);
    endtask

    task automatic test_rd_bad();
        n_tmo = 0; rd_bad = 1; wr_bad = 0;
        pulse_init(1'b1);
        chk("R2 init clears err", {err, aux_rst_n, iddq}, 3'b001);
        wait_end("R11");
        chk("R11 read error no retry", rd_count, 1);
        chk("R11 read error flags", {done, err, wr_count[3:0]}, {2'b01, 4'd0});
    endtask

    task automatic test_wr_bad();
        n_tmo = 0; rd_bad = 0; wr_bad = 1;
        pulse_init(1'b0);
        wait_end("R11");
        chk("R11 write error", {done, err, wr_count[3:0]}, {2'b01, 4'd1});
        wr_bad = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_init_pad();
        test_exit();
        test_simul();
        test_init_abb_retry();
        test_busy_ignored();
        test_exhaust();
        test_rd_bad();
        test_wr_bad();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule